// File: doc/BRIEF.md
# Min-Sum Check/Variable Processing Element

This block is the arithmetic cell of a successive-cancellation polar decoder. Each cycle it receives two log-likelihood ratios in sign-magnitude form, a partial-sum bit and a mode select. It returns one sign-magnitude LLR on the following clock edge. In check mode it forms the min-sum estimate: the smaller input magnitude, signed by the parity of the input signs. In variable mode it adds the first LLR to the second, or subtracts it from the second, depending on the partial-sum bit.

Inside, both inputs pass through sign-magnitude to two's complement converters. A sum and a difference are formed in parallel, and each goes through its own saturating converter back to sign-magnitude. The partial-sum bit picks one of the two, and the mode select then chooses between that result and the min-sum result. A decoder schedules one of these cells per node and feeds it from its own LLR memory.

Top module: `minsum_pe`

## Requirements
- R1: In check mode (`sel_g`=0) the output magnitude equals the smaller of the two input magnitudes.
- R2: In check mode, when the resulting magnitude is nonzero, the output sign is the XOR of the two input sign bits.
- R3: In variable mode (`sel_g`=1) with `psum`=0, the output is the value of `llr_b` plus the value of `llr_a`.
- R4: In variable mode with `psum`=1, the output is the value of `llr_b` minus the value of `llr_a`.
- R5: A variable-mode result beyond ±(2^(W-1)-1) saturates to that limit with the sign of the exact result.
- R6: An input with sign bit 1 and magnitude 0 is handled as the value zero.
- R7: The output never carries sign 1 with magnitude 0. A zero result is all bits 0.
- R8: The output is registered. A result appears on the first rising edge after its inputs are applied, and an active-low reset clears the output to 0.
- R9: Every LLR port uses bit W-1 as the sign (1 = negative) and bits W-2..0 as an unsigned magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| llr_a | input | W | First LLR, sign-magnitude |
| llr_b | input | W | Second LLR, sign-magnitude |
| psum | input | 1 | Partial-sum bit: 0 adds, 1 subtracts (variable mode) |
| sel_g | input | 1 | Mode: 0 check (min-sum), 1 variable (add/subtract) |
| out_llr | output | W | Registered result LLR, sign-magnitude |

## Verification
The assertions assume that `llr_a`, `llr_b`, `psum` and `sel_g` hold known values at each rising edge once reset has been released. They also assume that any sign-magnitude code may arrive, including negative zero. The one-cycle properties compare the output with the inputs sampled on the previous edge, so those inputs must stay steady across the sampling edge. The stimulus changes inputs only on falling edges, and it covers every pair of codes in both modes with both partial-sum values. The negative-zero and saturating corners are therefore reached by the sweep itself and need no extra constraint.

// File: rtl/minsum_pkg.sv
package minsum_pkg;
  typedef enum logic {
    PE_CHECK = 1'b0,
    PE_VAR   = 1'b1
  } pe_mode_e;
endpackage

// File: rtl/sm2tc.sv
module sm2tc #(
  parameter int W = 5
) (
  input  logic [W-1:0]        sm,
  output logic signed [W-1:0] tc
);
  localparam int MW = W - 1;

  function automatic logic signed [W-1:0] to_tc(input logic [W-1:0] v);
    logic signed [W-1:0] m;
    m = $signed({1'b0, v[MW-1:0]});
    return v[W-1] ? -m : m;
  endfunction

  always_comb begin
    tc = to_tc(sm);
    // R6
    if (sm[MW-1:0] == '0) begin
      negzero_in_chk: assert (tc == '0);
    end
  end
endmodule

// File: rtl/tc2sm.sv
module tc2sm #(
  parameter int W = 5
) (
  input  logic signed [W:0] v,
  output logic [W-1:0]      sm
);
  localparam int MW = W - 1;
  localparam int MAXM = (1 << MW) - 1;
  localparam logic signed [W:0] POS_LIM = MAXM[W:0];
  localparam logic signed [W:0] NEG_LIM = -POS_LIM;

  function automatic logic [W-1:0] to_sm(input logic signed [W:0] x);
    logic signed [W:0] a;
    logic [MW-1:0]     m;
    if (x > POS_LIM)      m = MAXM[MW-1:0];
    else if (x < NEG_LIM) m = MAXM[MW-1:0];
    else begin
      a = (x < 0) ? -x : x;
      m = a[MW-1:0];
    end
    return {(x < 0) && (m != '0), m};
  endfunction

  always_comb begin
    sm = to_sm(v);
    // R5
    if (v > POS_LIM || v < NEG_LIM) begin
      sat_clamp_chk: assert (sm[MW-1:0] == MAXM[MW-1:0] && sm[W-1] == v[W]);
    end
  end
endmodule

// File: rtl/fg_cmpsel.sv
module fg_cmpsel #(
  parameter int W = 5
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] f
);
  localparam int MW = W - 1;

  logic [MW-1:0] mag_a, mag_b, mag_min;
  logic          a_smaller;

  assign mag_a     = a[MW-1:0];
  assign mag_b     = b[MW-1:0];
  assign a_smaller = mag_a < mag_b;
  assign mag_min   = a_smaller ? mag_a : mag_b;

  function automatic logic f_sign(input logic sa, input logic sb,
                                  input logic [MW-1:0] m);
    return (m != '0) && (sa ^ sb);
  endfunction

  assign f = {f_sign(a[W-1], b[W-1], mag_min), mag_min};

  always_comb begin
    // R1
    f_min_chk: assert (f[MW-1:0] <= mag_a && f[MW-1:0] <= mag_b);
  end
endmodule

// File: rtl/g_addsub.sv
module g_addsub #(
  parameter int W = 5
) (
  input  logic signed [W-1:0] a_tc,
  input  logic signed [W-1:0] b_tc,
  input  logic                psum,
  output logic [W-1:0]        g
);
  logic signed [W:0] sum_w, dif_w;
  logic [W-1:0]      sum_sm, dif_sm;

  assign sum_w = {b_tc[W-1], b_tc} + {a_tc[W-1], a_tc};
  assign dif_w = {b_tc[W-1], b_tc} - {a_tc[W-1], a_tc};

  tc2sm #(.W(W)) u_sum (.v(sum_w), .sm(sum_sm));
  tc2sm #(.W(W)) u_dif (.v(dif_w), .sm(dif_sm));

  assign g = psum ? dif_sm : sum_sm;
endmodule

// File: rtl/minsum_pe.sv
module minsum_pe
  import minsum_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] llr_a,
  input  logic [W-1:0] llr_b,
  input  logic         psum,
  input  logic         sel_g,
  output logic [W-1:0] out_llr
);
  localparam int MW = W - 1;
  localparam int NIN = 2;

  logic [W-1:0]        sm_in [NIN];
  logic signed [W-1:0] tc_in [NIN];
  logic [W-1:0]        f_res, g_res, nxt;
  pe_mode_e            mode;

  assign sm_in[0] = llr_a;
  assign sm_in[1] = llr_b;
  assign mode     = pe_mode_e'(sel_g);

  for (genvar i = 0; i < NIN; i++) begin : g_conv
    sm2tc #(.W(W)) u_cv (.sm(sm_in[i]), .tc(tc_in[i]));
  end

  fg_cmpsel #(.W(W)) u_f (.a(llr_a), .b(llr_b), .f(f_res));

  g_addsub #(.W(W)) u_g (
    .a_tc(tc_in[0]), .b_tc(tc_in[1]), .psum(psum), .g(g_res)
  );

  assign nxt = (mode == PE_VAR) ? g_res : f_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_llr <= '0;
    else        out_llr <= nxt;
  end

  // R7
  no_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_llr[W-1] && out_llr[MW-1:0] == '0));

  // R2
  f_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_g && llr_a[MW-1:0] != '0 && llr_b[MW-1:0] != '0)
      |=> out_llr[W-1] == ($past(llr_a[W-1]) ^ $past(llr_b[W-1])));

  // R3
  g_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_g && !psum && !llr_a[W-1] && !llr_b[W-1]) |=> !out_llr[W-1]);

  // R4
  g_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_g && psum && llr_a == llr_b) |=> out_llr == '0);

  // R1
  f_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_g) |=> (out_llr[MW-1:0] <= $past(llr_a[MW-1:0]) &&
                  out_llr[MW-1:0] <= $past(llr_b[MW-1:0])));
endmodule

// File: tb/sim_minsum_pe.sv
module sim_minsum_pe;
  localparam int W = 5;
  localparam int LIM = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] llr_a, llr_b, out_llr;
  logic psum, sel_g;
  int n_cmp = 0, n_bad = 0, n_negzero = 0;
  bit done = 0;

  always #5 clk = ~clk;

  minsum_pe #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .llr_a(llr_a), .llr_b(llr_b),
    .psum(psum), .sel_g(sel_g), .out_llr(out_llr)
  );

  function automatic int val(input logic [W-1:0] v);
    int m = int'(v[W-2:0]);
    return v[W-1] ? -m : m;
  endfunction

  function automatic logic [W-1:0] enc(input int v);
    int c = v;
    if (c > LIM) c = LIM;
    if (c < -LIM) c = -LIM;
    if (c < 0) return {1'b1, (W-1)'(-c)};
    return {1'b0, (W-1)'(c)};
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b,
                                         input logic p, g);
    int x = val(a), y = val(b);
    int ax = x < 0 ? -x : x;
    int ay = y < 0 ? -y : y;
    int m = ax < ay ? ax : ay;
    if (!g) return enc(((x < 0) != (y < 0)) ? -m : m);
    return enc(p ? y - x : y + x);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, exp);
    n_cmp++;
    if (got[W-1] && got[W-2:0] == '0) n_negzero++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  logic [W-1:0] exp_q[$];
  string tag_q[$];

  initial begin
    rst_n = 1'b0; llr_a = '0; llr_b = '0; psum = 1'b0; sel_g = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", out_llr, '0);
    rst_n = 1'b1;
    // R9: +3 and -1 in variable add mode give +2 = 00010
    @(negedge clk);
    llr_a = 5'b00011; llr_b = 5'b10001; sel_g = 1'b1; psum = 1'b0;
    #1 check("R8", out_llr, '0);
    @(negedge clk);
    check("R9", out_llr, 5'b00010);
    for (int gm = 0; gm < 2; gm++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < (1 << W); a++) begin
          for (int b = 0; b < (1 << W); b++) begin
            logic [W-1:0] av, bv;
            string t;
            int r;
            av = W'(a); bv = W'(b);
            if (exp_q.size() > 0) check(tag_q.pop_front(), out_llr, exp_q.pop_front());
            llr_a = av; llr_b = bv; psum = p[0]; sel_g = gm[0];
            r = p ? val(bv) - val(av) : val(bv) + val(av);
            if ((av[W-1] && av[W-2:0] == '0) || (bv[W-1] && bv[W-2:0] == '0)) t = "R6";
            else if (gm == 0) t = (av[W-2:0] != '0 && bv[W-2:0] != '0) ? "R2" : "R1";
            else if (r > LIM || r < -LIM) t = "R5";
            else t = p ? "R4" : "R3";
            exp_q.push_back(model(av, bv, p[0], gm[0]));
            tag_q.push_back(t);
            @(negedge clk);
          end
        end
      end
    end
    check(tag_q.pop_front(), out_llr, exp_q.pop_front());
    n_cmp++;
    if (n_negzero != 0) begin
      n_bad++;
      $display("FAIL R7: negative-zero outputs %0d expected 0", n_negzero);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule